// File: doc/BRIEF.md
# Conversion Result Read Port

This block holds the latest conversion results of a four-channel sampling converter and lets a host read them over a shared 12-bit parallel bus. Three main input channels and one auxiliary channel each have a dedicated result register. The conversion sequencer hands over a new result set with a single commit strobe and a per-channel mask, so a sequence that converts only some channels updates only those registers.

The host selects a register with a 2-bit address and reads it by pulling an active-low chip select and an active-low read strobe. The bus is modelled as an output enable plus a data vector. The address decode and data path are combinational, so read data follows the address and strobes within the same cycle. The 11-bit result sits in the upper bits of the bus word, and the lowest bit always reads as zero. Until the sequencer commits, a read returns the previous result set.

Top module: `result_read_port`

## Requirements
- R1: After reset every result register holds zero, so a read at any address returns 0x000.
- R2: `bus_oe` is 1 only when `cs_n` and `rd_n` are both 0. Otherwise `bus_oe` is 0 and `bus_data` is all zeros.
- R3: Address map: `addr` 2'b00 reads main channel 1, 2'b01 main channel 2, 2'b10 main channel 3 and 2'b11 the auxiliary channel.
- R4: A read returns the selected 11-bit result in `bus_data[11:1]`, and `bus_data[0]` is always 0.
- R5: On a clock edge with `commit` high, each channel k whose `commit_mask[k]` bit is 1 loads `commit_data[k*11 +: 11]`. Mask bit 0 is main channel 1, bit 1 main channel 2, bit 2 main channel 3 and bit 3 the auxiliary channel. Channels with a mask bit of 0 keep their value.
- R6: Without a commit the registers hold. A read during a conversion, before the commit edge, returns the previous result.
- R7: Changing `addr` while the read is active switches `bus_data` in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| commit | input | 1 | Sequencer commit strobe for a new result set |
| commit_mask | input | 4 | Channels updated by this commit |
| commit_data | input | 44 | New results, channel k in bits k*11 +: 11 |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| addr | input | 2 | Register address |
| bus_oe | output | 1 | Bus drive enable |
| bus_data | output | 12 | Read data |

## Verification
A corrupted result register shows on the bus at the first read of that address after the bad edge. The bench therefore reads all four addresses after each commit, including commits with partial masks, to catch a wrong load or a register that failed to hold. A decode or enable fault shows at once on the combinational outputs. The bench samples within the same cycle after changing the address or strobes, so any fault that needs a clock edge to appear, or that leaves data on an idle bus, is reported straight away.

// File: rtl/rrp_pkg.sv
package rrp_pkg;
  localparam int DEF_RES_W = 11;
  localparam int DEF_N_CH  = 4;

  typedef enum logic [1:0] {
    SLOT_MAIN1 = 2'b00,
    SLOT_MAIN2 = 2'b01,
    SLOT_MAIN3 = 2'b10,
    SLOT_AUX   = 2'b11
  } slot_e;
endpackage

// File: rtl/rrp_result_bank.sv
module rrp_result_bank #(
  parameter int N_CH  = rrp_pkg::DEF_N_CH,
  parameter int RES_W = rrp_pkg::DEF_RES_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [N_CH-1:0]         load_mask,
  input  logic [N_CH*RES_W-1:0]   load_data,
  output logic [N_CH*RES_W-1:0]   bank
);
  // per-channel write strobes brought out for checking
  logic [N_CH-1:0] wr_hit;

  for (genvar k = 0; k < N_CH; k++) begin : g_reg
    assign wr_hit[k] = load & load_mask[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bank[k*RES_W +: RES_W] <= '0;
      else if (wr_hit[k]) bank[k*RES_W +: RES_W] <= load_data[k*RES_W +: RES_W];
    end

    assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_mask[k]) |=> bank[k*RES_W +: RES_W] == $past(load_data[k*RES_W +: RES_W]));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && load_mask[k]) |=> $stable(bank[k*RES_W +: RES_W]));
  end
endmodule

// File: rtl/rrp_addr_decode.sv
module rrp_addr_decode #(
  parameter int N_CH   = rrp_pkg::DEF_N_CH,
  localparam int ADDR_W = $clog2(N_CH)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_CH-1:0]   sel
);
  always_comb begin
    sel = '0;
    sel[addr] = 1'b1;
  end

  always_comb begin
    assert_sel_onehot_R3: assert ($onehot(sel));
    assert_aux_slot_R3: assert (!(addr == rrp_pkg::SLOT_AUX) || sel[N_CH-1]);
  end
endmodule

// File: rtl/rrp_bus_driver.sv
module rrp_bus_driver #(
  parameter int N_CH  = rrp_pkg::DEF_N_CH,
  parameter int RES_W = rrp_pkg::DEF_RES_W,
  localparam int BUS_W = RES_W + 1
) (
  input  logic                  cs_n,
  input  logic                  rd_n,
  input  logic [N_CH-1:0]       sel,
  input  logic [N_CH*RES_W-1:0] bank,
  output logic                  oe,
  output logic [BUS_W-1:0]      data
);
  function automatic logic [BUS_W-1:0] to_bus(input logic [RES_W-1:0] r);
    return {r, 1'b0};
  endfunction

  logic [RES_W-1:0] picked;
  logic [RES_W-1:0] terms [N_CH];

  for (genvar k = 0; k < N_CH; k++) begin : g_and
    assign terms[k] = bank[k*RES_W +: RES_W] & {RES_W{sel[k]}};
  end

  always_comb begin
    picked = '0;
    for (int k = 0; k < N_CH; k++) picked = picked | terms[k];
  end

  assign oe   = ~cs_n & ~rd_n;
  assign data = oe ? to_bus(picked) : '0;

  always_comb begin
    assert_idle_zero_R2: assert (oe || data == '0);
    assert_lsb_zero_R4: assert (data[0] == 1'b0);
  end
endmodule

// File: rtl/result_read_port.sv
module result_read_port #(
  parameter int N_CH  = rrp_pkg::DEF_N_CH,
  parameter int RES_W = rrp_pkg::DEF_RES_W,
  localparam int ADDR_W = $clog2(N_CH),
  localparam int BUS_W  = RES_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  logic [N_CH-1:0]       commit_mask,
  input  logic [N_CH*RES_W-1:0] commit_data,
  input  logic                  cs_n,
  input  logic                  rd_n,
  input  logic [ADDR_W-1:0]     addr,
  output logic                  bus_oe,
  output logic [BUS_W-1:0]      bus_data
);
  logic [N_CH*RES_W-1:0] bank;
  logic [N_CH-1:0]       sel;

  rrp_result_bank #(.N_CH(N_CH), .RES_W(RES_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .load(commit), .load_mask(commit_mask),
    .load_data(commit_data), .bank(bank)
  );

  rrp_addr_decode #(.N_CH(N_CH)) u_dec (.addr(addr), .sel(sel));

  rrp_bus_driver #(.N_CH(N_CH), .RES_W(RES_W)) u_drv (
    .cs_n(cs_n), .rd_n(rd_n), .sel(sel), .bank(bank),
    .oe(bus_oe), .data(bus_data)
  );

  assert_oe_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe == (!cs_n && !rd_n));

  assert_read_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> bus_data[BUS_W-1:1] == bank[addr*RES_W +: RES_W]);
endmodule

// File: tb/sim_result_read_port.sv
module sim_result_read_port;
  localparam int N = 4;
  localparam int W = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          commit = 1'b0;
  logic [N-1:0]  commit_mask = '0;
  logic [N*W-1:0] commit_data = '0;
  logic          cs_n = 1'b1;
  logic          rd_n = 1'b1;
  logic [1:0]    addr = 2'b00;
  logic          bus_oe;
  logic [11:0]   bus_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] model [N];

  always #2 clk = ~clk;

  result_read_port u0 (.*);

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_at(input logic [1:0] a, input string req);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    #1;
    check(req, {bus_oe, bus_data}, {1'b1, model[a], 1'b0});
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < N; a++) read_at(a[1:0], req);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic do_commit(input logic [N-1:0] m, input logic [N*W-1:0] d);
    @(negedge clk);
    commit = 1'b1; commit_mask = m; commit_data = d;
    @(posedge clk);
    for (int k = 0; k < N; k++) if (m[k]) model[k] = d[k*W +: W];
    @(negedge clk);
    commit = 1'b0; commit_mask = '0; commit_data = '0;
  endtask

  task automatic t_reset;
    for (int k = 0; k < N; k++) model[k] = '0;
    read_all("R1 reset");
  endtask

  task automatic t_strobes;
    addr = 2'b01;
    cs_n = 1'b1; rd_n = 1'b0; #1; check("R2 cs high", {bus_oe, bus_data}, 13'h0);
    cs_n = 1'b0; rd_n = 1'b1; #1; check("R2 rd high", {bus_oe, bus_data}, 13'h0);
    cs_n = 1'b1; rd_n = 1'b1; #1; check("R2 idle", {bus_oe, bus_data}, 13'h0);
    cs_n = 1'b0; rd_n = 1'b0; #1; check("R2 both low", {12'h0, bus_oe}, 13'h1);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic t_full_commit;
    do_commit(4'b1111, {11'h7FF, 11'h2AA, 11'h155, 11'h001});
    read_all("R3 R4 R5 full set");
  endtask

  task automatic t_partial;
    do_commit(4'b0110, {11'h0F0, 11'h333, 11'h444, 11'h0F0});
    read_all("R5 partial mask");
    do_commit(4'b1000, {11'h123, 11'h7FF, 11'h7FF, 11'h7FF});
    read_all("R5 aux only");
  endtask

  task automatic t_hold_during_conv;
    @(negedge clk);
    commit_data = {11'h3C3, 11'h0AA, 11'h055, 11'h600};
    commit_mask = 4'b1111;
    read_all("R6 data present, no commit");
    @(negedge clk);
    read_all("R6 hold across edges");
    commit_mask = '0; commit_data = '0;
    do_commit(4'b1111, {11'h3C3, 11'h0AA, 11'h055, 11'h600});
    read_all("R6 new set after commit");
  endtask

  task automatic t_addr_switch;
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0;
    addr = 2'b00; #0.5; check("R7 addr0", {bus_oe, bus_data}, {1'b1, model[0], 1'b0});
    addr = 2'b11; #0.5; check("R7 addr3", {bus_oe, bus_data}, {1'b1, model[3], 1'b0});
    addr = 2'b10; #0.5; check("R7 addr2", {bus_oe, bus_data}, {1'b1, model[2], 1'b0});
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic t_reset_again;
    @(negedge clk);
    commit = 1'b1; commit_mask = 4'b1111; commit_data = '1;
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    commit = 1'b0; commit_mask = '0; commit_data = '0;
    rst_n = 1'b1;
    for (int k = 0; k < N; k++) model[k] = '0;
    read_all("R1 reset clears");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_strobes;
    t_full_commit;
    t_partial;
    t_hold_during_conv;
    t_addr_switch;
    t_reset_again;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule